// File: doc/BRIEF.md
# Runtime-Configurable Segmented Speculative Adder

This block adds two WIDTH-bit operands by cutting the carry chain into equal SEG-bit sub-adders. Each segment boundary has a two-way carry selector, and a link vector drives these selectors at run time. A linked boundary passes the real carry-out of the segment below. Chains of linked segments therefore act as one longer exact adder. An unlinked boundary isolates the segment above it. That segment then takes a guessed carry. The guess is the carry-out of an OVL-bit addition of the operand bits just below the boundary, with that addition's carry-in at 0. When OVL is 0, the guess is the constant 0.

The operands and the link vector are sampled on each rising clock edge. The sum and the carry-out are registered, so a new addition can start every cycle. Software or a control loop can trade accuracy against carry-chain length for each operation, with no change to the hardware. WIDTH, SEG and OVL are compile-time parameters. WIDTH must be a multiple of SEG, SEG must be smaller than WIDTH, and OVL must be smaller than SEG.

Top module: `seg_spec_adder`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, `sum` and `cout` are 0 after that edge, whatever the other inputs are.
- R2: Operands and link bits sampled at a rising edge appear as the result on `sum`/`cout` right after that edge. A different operand pair may be applied every cycle.
- R3: When every bit of `link` is 1, `{cout, sum}` equals the exact WIDTH+1-bit sum of `op_a` and `op_b`.
- R4: With OVL>0, a boundary j whose `link[j]` is 0 feeds segment j+1 a carry equal to the carry-out of adding operand bits [SEG*(j+1)-1 : SEG*(j+1)-OVL] of `op_a` and `op_b` with carry-in 0.
- R5: With OVL=0, a segment above an unlinked boundary receives a carry-in of 0.
- R6: `sum[SEG-1:0]` always equals the low SEG bits of `op_a + op_b`, whatever `link` holds.
- R7: `link[j]` = 1 (bit j governs the boundary between segment j and segment j+1, segment 0 being the least significant) feeds segment j+1 the true carry-out of segment j, as computed with segment j's own selected carry-in.
- R8: `cout` is the carry-out of the most significant segment under that segment's selected carry-in.
- R9: Each link bit acts on its own boundary only. In any mix of link values, every run of linked segments adds exactly over its span, using the carry that enters the run's lowest segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| link | input | WIDTH/SEG-1 | Per-boundary carry select: 1 = true carry, 0 = guessed carry |
| sum | output | WIDTH | Registered sum |
| cout | output | 1 | Registered carry-out of the top segment |

## Verification
The case that is hardest to bring about is a wrong guess: an isolated segment must receive a carry that differs from the true one. That requires a carry born below the OVL-bit guess window that ripples through the window into the boundary. Directed operands such as 0x000F + 0x0001 create this on purpose. Operands such as 0x000C + 0x0004 show the opposite case, where the guess window alone produces the carry. Both cases run on a default instance and on a second instance with OVL=0, so the two guess variants diverge on identical stimulus. Random operands under every link mix then cover how grouped and isolated segments interact.

// File: rtl/ssa_pkg.sv
// Shared definitions for the segmented speculative adder.
// Assumes: nothing beyond the user's parameters.
package ssa_pkg;
    // Carry source chosen at one segment boundary.
    typedef enum logic {
        LINK_SPEC = 1'b0,
        LINK_TRUE = 1'b1
    } link_mode_e;

    // Number of sub-adders for a given total width and segment width.
    function automatic int seg_count(input int width, input int seg);
        return width / seg;
    endfunction
endpackage

// File: rtl/ssa_subadder.sv
// One exact SEG-bit sub-adder with a carry-in and a carry-out.
// Assumes: W >= 1. Purely combinational.
module ssa_subadder #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         ci,
    output logic [W-1:0] s,
    output logic         co
);
    // Full-width addition including the incoming carry.
    always_comb begin
        {co, s} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    end
endmodule

// File: rtl/ssa_carry_guess.sv
// Guesses the carry entering a segment from the OVL operand bits just
// below it. The guess is the carry-out of those bits added with carry-in 0.
// Assumes: OVL >= 1. The OVL=0 variant is handled by the parent.
module ssa_carry_guess #(
    parameter int OVL = 2
) (
    input  logic [OVL-1:0] a_lo,
    input  logic [OVL-1:0] b_lo,
    output logic           guess
);
    // Generate/propagate ripple over the guess window, starting from 0.
    always_comb begin
        logic c;
        c = 1'b0;
        for (int i = 0; i < OVL; i++) begin
            c = (a_lo[i] & b_lo[i]) | (c & (a_lo[i] ^ b_lo[i]));
        end
        guess = c;
    end
endmodule

// File: rtl/seg_spec_adder.sv
// Segmented speculative adder. WIDTH is split into SEG-bit sub-adders.
// link[j] picks, for the boundary above segment j, either the true carry
// (1) or the guessed carry (0). The result is registered once.
// Assumes: WIDTH % SEG == 0, SEG < WIDTH, OVL < SEG. Synchronous active-low reset.
module seg_spec_adder
    import ssa_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int SEG   = 4,
    parameter int OVL   = 2
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [WIDTH-1:0]                      op_a,
    input  logic [WIDTH-1:0]                      op_b,
    input  logic [seg_count(WIDTH, SEG)-2:0]      link,
    output logic [WIDTH-1:0]                      sum,
    output logic                                  cout
);
    localparam int NSEG  = seg_count(WIDTH, SEG);
    localparam int NLINK = NSEG - 1;

    logic [WIDTH-1:0] sum_d;
    logic             top_co;

    // One sub-adder per segment, each with its own carry selector.
    for (genvar s = 0; s < NSEG; s++) begin : seg_g
        logic ci;
        logic co;

        if (s == 0) begin : g_base
            // The lowest segment always starts from carry 0.
            assign ci = 1'b0;
        end else begin : g_upper
            logic guess;
            if (OVL > 0) begin : g_pred
                ssa_carry_guess #(.OVL(OVL)) u_guess (
                    .a_lo  (op_a[s*SEG-1 -: OVL]),
                    .b_lo  (op_b[s*SEG-1 -: OVL]),
                    .guess (guess)
                );
            end else begin : g_zero
                assign guess = 1'b0;
            end
            // Boundary selector: true ripple carry or guessed carry.
            assign ci = (link_mode_e'(link[s-1]) == LINK_TRUE) ? seg_g[s-1].co : guess;
        end

        ssa_subadder #(.W(SEG)) u_sub (
            .a  (op_a[s*SEG +: SEG]),
            .b  (op_b[s*SEG +: SEG]),
            .ci (ci),
            .s  (sum_d[s*SEG +: SEG]),
            .co (co)
        );
    end

    assign top_co = seg_g[NSEG-1].co;

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum  <= '0;
            cout <= 1'b0;
        end else begin
            sum  <= sum_d;
            cout <= top_co;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sum == '0) && !cout);

    // R3
    exact_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&link) |=> {cout, sum} == $past({1'b0, op_a} + {1'b0, op_b}));

    // R6
    low_seg_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> sum[SEG-1:0] == $past(op_a[SEG-1:0] + op_b[SEG-1:0]));

    // R4 R5: an isolated segment adds only its own bits plus the guess.
    for (genvar j = 0; j < NLINK; j++) begin : chk_g
        localparam int LO = (j + 1) * SEG;
        if (OVL > 0) begin : g_p
            // R4
            spec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (link[j] == 1'b0) |=> sum[LO +: SEG] == $past(op_a[LO +: SEG] + op_b[LO +: SEG]
                    + SEG'(({1'b0, op_a[LO-1 -: OVL]} + {1'b0, op_b[LO-1 -: OVL]}) >> OVL)));
        end else begin : g_z
            // R5
            zero_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (link[j] == 1'b0) |=> sum[LO +: SEG] == $past(op_a[LO +: SEG] + op_b[LO +: SEG]));
        end
    end
endmodule

// File: tb/test_seg_spec_adder.sv
module test_seg_spec_adder;
    localparam int W  = 16;
    localparam int K  = 4;
    localparam int L  = 2;
    localparam int NL = W / K - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  op_a = '0;
    logic [W-1:0]  op_b = '0;
    logic [NL-1:0] link = '0;
    logic [W-1:0]  sum, sum0;
    logic          cout, cout0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [W:0]    exp_p;
        logic [W:0]    exp_z;
        logic [K-1:0]  exp_low;
        string         tag;
    } item_t;
    item_t sb[$];

    always #2 clk = ~clk;  // 250 MHz

    seg_spec_adder #(.WIDTH(W), .SEG(K), .OVL(L)) i_seg_spec_adder (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .link(link),
        .sum(sum), .cout(cout));

    seg_spec_adder #(.WIDTH(W), .SEG(K), .OVL(0)) i_seg_spec_adder_nopred (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .link(link),
        .sum(sum0), .cout(cout0));

    // Bit-accurate model of the segmented adder built from the requirements.
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic [NL-1:0] lk, input int ovl);
        int unsigned res = 0, prev_co = 0, c, sa, sb2, segsum, km, om;
        km = (1 << K) - 1;
        for (int s = 0; s <= NL; s++) begin
            if (s == 0) c = 0;
            else if (lk[s-1]) c = prev_co;                      // R7
            else if (ovl == 0) c = 0;                           // R5
            else begin                                          // R4
                om = (1 << ovl) - 1;
                c = ((((a >> (s*K - ovl)) & om) + ((b >> (s*K - ovl)) & om)) >> ovl) & 1;
            end
            sa = (a >> (s*K)) & km;
            sb2 = (b >> (s*K)) & km;
            segsum = sa + sb2 + c;
            res = res | ((segsum & km) << (s*K));
            prev_co = (segsum >> K) & 1;
        end
        return {prev_co[0], res[W-1:0]};                        // R8
    endfunction

    task automatic check(input bit ok, input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver: applies one operation and queues the expected outputs.
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [NL-1:0] lk, input string tag, input bit exact);
        item_t it;
        @(negedge clk);
        op_a = a; op_b = b; link = lk;
        it.exp_p = exact ? ({1'b0, a} + {1'b0, b}) : model(a, b, lk, L);
        it.exp_z = exact ? ({1'b0, a} + {1'b0, b}) : model(a, b, lk, 0);
        it.exp_low = a[K-1:0] + b[K-1:0];
        it.tag = tag;
        sb.push_back(it);
    endtask

    // Monitor: one edge after each drive, compare both instances (R2 latency).
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check({cout, sum} === it.exp_p, {it.tag, " ovl2"}, {cout, sum}, it.exp_p);
                check({cout0, sum0} === it.exp_z, {it.tag, " ovl0"}, {cout0, sum0}, it.exp_z);
                check(sum[K-1:0] === it.exp_low, "R6 low segment", {{(W+1-K){1'b0}}, sum[K-1:0]},
                      {{(W+1-K){1'b0}}, it.exp_low});
            end
        end
    end

    task automatic reset_check();
        @(negedge clk);
        rst_n = 1'b0; op_a = 16'hFFFF; op_b = 16'h1234; link = '1;
        repeat (2) @(posedge clk);
        #1;
        check({cout, sum} === '0, "R1 reset", {cout, sum}, '0);
        check({cout0, sum0} === '0, "R1 reset nopred", {cout0, sum0}, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        reset_check();
        // R3: all boundaries linked gives the exact sum
        drive(16'hFFFF, 16'h0001, '1, "R3 carry through all", 1);
        drive(16'hFFFF, 16'hFFFF, '1, "R3 max", 1);
        drive(16'h0000, 16'h0000, '1, "R3 zero", 1);
        drive(16'h8000, 16'h8000, '1, "R3 top carry", 1);
        for (int i = 0; i < 40; i++)
            drive(16'($urandom), 16'($urandom), '1, "R3 R2 random", 1);
        // R4/R5: guess misses a carry born below the window
        drive(16'h000F, 16'h0001, '0, "R4 R5 missed carry", 0);
        // R4: guess window generates the carry itself; R5 gives 0
        drive(16'h000C, 16'h0004, '0, "R4 R5 window carry", 0);
        drive(16'h0F0C, 16'h00F4, '0, "R4 R5 multi boundary", 0);
        // R8: carry-out from top segment under isolation
        drive(16'hF000, 16'h1000, '0, "R8 top isolated", 0);
        drive(16'hF8FF, 16'h0801, 3'b100, "R8 top linked", 0);
        // R9 / R7: mixed link patterns
        drive(16'h0FFF, 16'h0001, 3'b011, "R7 chain", 0);
        drive(16'h0FFF, 16'h0001, 3'b101, "R9 mix 101", 0);
        for (int m = 0; m < 8; m++)
            for (int i = 0; i < 12; i++)
                drive(16'($urandom), 16'($urandom), NL'(m), "R9 R7 random mix", 0);
        // R1: reset in the middle of activity
        @(posedge clk); #1;
        reset_check();
        drive(16'h1234, 16'h4321, '0, "R2 after reset", 0);
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule